// File: doc/BRIEF.md
# Prioritized nesting interrupt controller

This block collects up to 35 level-type peripheral interrupt lines for a small processor core and decides which one, if any, to offer the core next. Each line has a pending flag, an active flag and a 4-bit priority value, where a smaller value is more urgent. A line becomes pending when it is high while its handler is not running, and also when it goes from low to high. Software can set or clear a line's pending flag directly. Among the pending lines the one with the smallest priority value wins, and on a tie the lowest line number wins.

The core accepts the offered interrupt with a one-cycle take pulse and signals handler exit with a one-cycle return pulse. Accepted interrupts are kept on a last-in-first-out stack of running handlers, and the top entry is shown to the core. A programmable split point divides each priority value into an upper group field and a lower subpriority field. A new request is offered only when the winner's group is strictly more urgent than the group of the handler now running. When a handler exits, its line is sampled again, and the line re-pends if it is still high.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all pending flags are 0, `req_o` is 0, `act_valid_o` is 0 and every priority value is 0.
- R2: A line sampled high at a clock edge while its handler is not active has its pending bit set after that edge.
- R3: `req_id_o` names the pending line with the smallest priority value. On a tie, the lowest line number wins.
- R4: A take pulse while `req_o` is 1 pushes `req_id_o` on the handler stack (`act_id_o` shows it next cycle). It also clears that line's pending bit unless the line is still high. A take pulse while `req_o` is 0 has no effect.
- R5: The group of a priority value p is p >> s, where s is the split value. While a handler runs, `req_o` is 1 only if the winner's group is strictly smaller than the group of the running handler's priority, captured at take. An equal group with a smaller subpriority does not raise `req_o`. When no handler runs, any pending winner raises `req_o`.
- R6: A return pulse retires the top handler, and `act_id_o` then shows the handler below it. Take and return in the same cycle replace the top entry with the new id, and the stack depth stays the same.
- R7: On return, a retiring line that is still high is pending after that edge, so it is offered again at once.
- R8: A rising edge on a line whose handler is active sets its pending bit.
- R9: `sw_set_i[n]` sets pending bit n and `sw_clr_i[n]` clears it. If both are given, set wins. Clear wins over a hardware set in the same cycle.
- R10: A write with `reg_addr_i` = n (n < 35) loads `reg_wdata_i[3:0]` as the priority of line n. A write to address 63 loads the split value s; values above 4 are stored as 4.
- R11: The stack holds up to 16 handlers, and `act_valid_o` is 0 when it is empty. A return pulse with an empty stack has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 35 | Peripheral interrupt lines, high = request |
| sw_set_i | input | 35 | Software set-pending strobes |
| sw_clr_i | input | 35 | Software clear-pending strobes |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Register address: line priority or split (63) |
| reg_wdata_i | input | 8 | Register write data |
| take_i | input | 1 | Core accepts the offered interrupt |
| ret_i | input | 1 | Core returns from the running handler |
| req_o | output | 1 | An interrupt is offered to the core |
| req_id_o | output | 6 | Line number of the offered interrupt |
| pend_o | output | 35 | Pending flags |
| act_valid_o | output | 1 | At least one handler is running |
| act_id_o | output | 6 | Line number of the innermost running handler |

## Verification
Take and return can fall in the same cycle. A return then retires the innermost handler while a more urgent pending line is accepted, and the stack top must be replaced rather than grown or shrunk. The bench builds a two-deep stack from software-set lines. It then pends a third line of more urgent group and pulses take and return together. It judges the result from the new `act_id_o`, and then from two more returns that must expose the outermost entry and finally an empty stack. A return that retires a line while that line is still high is also checked: the same edge clears the active state and re-pends the line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned MAX_IRQ = 35;

  function automatic logic [7:0] clamp_split(input logic [7:0] v, input logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [7:0] group_of(input logic [7:0] prio, input logic [7:0] split);
    return prio >> split;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned NUM_IRQ = 35,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned SPLIT_W = $clog2(PRIO_W + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_o,
  output logic [SPLIT_W-1:0]             split_o
);
  import irq_pkg::*;
  localparam logic [ADDR_W-1:0] SPLIT_ADDR = {ADDR_W{1'b1}};

  logic [7:0] split_w;
  assign split_w = clamp_split(8'(wdata_i), 8'(PRIO_W));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    prio_o[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))          prio_o[i] <= wdata_i[PRIO_W-1:0];
    end

    AST_PRIO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(i) |=> prio_o[i] == $past(wdata_i[PRIO_W-1:0])); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              split_o <= '0;
    else if (we_i && addr_i == SPLIT_ADDR)    split_o <= split_w[SPLIT_W-1:0];
  end

  AST_SPLIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == SPLIT_ADDR |=> split_o <= SPLIT_W'(PRIO_W)); // R10
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NUM_IRQ = 35
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  input  logic [NUM_IRQ-1:0] act_i,
  input  logic [NUM_IRQ-1:0] take_hit_i,
  input  logic [NUM_IRQ-1:0] ret_hit_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic hw_set, keep, nxt;
    // level on idle line, edge at any time, or level re-sampled at handler exit
    assign hw_set = (irq_i[i] & ~act_i[i]) | (irq_i[i] & ~irq_q[i]) | (ret_hit_i[i] & irq_i[i]);
    assign keep   = take_hit_i[i] ? irq_i[i] : (pend_o[i] | hw_set);
    assign nxt    = sw_set_i[i] | (~sw_clr_i[i] & keep);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= nxt;
    end

    AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] && !act_i[i] && !sw_clr_i[i] && !take_hit_i[i] |=> pend_o[i]); // R2
    AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] && !irq_q[i] && !sw_clr_i[i] && !take_hit_i[i] |=> pend_o[i]); // R8
    AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_clr_i[i] && !sw_set_i[i] |=> !pend_o[i]); // R9
    AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_set_i[i] |=> pend_o[i]); // R9
    AST_TAKE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_hit_i[i] && !irq_i[i] && !sw_set_i[i] |=> !pend_o[i]); // R4
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned NUM_IRQ = 35,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned ID_W   = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]             pend_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  output logic                           win_valid_o,
  output logic [ID_W-1:0]                win_id_o,
  output logic [PRIO_W-1:0]              win_prio_o
);
  // strict compare keeps the lower index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_prio_o  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend_i[i] && (!win_valid_o || prio_i[i] < win_prio_o)) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  output logic              top_valid_o,
  output logic [ID_W-1:0]   top_id_o,
  output logic [PRIO_W-1:0] top_prio_o
);
  logic [DEPTH-1:0][ID_W-1:0]   id_mem;
  logic [DEPTH-1:0][PRIO_W-1:0] prio_mem;
  logic [CNT_W-1:0]             cnt;
  logic [IDX_W-1:0]             top_idx, wr_idx;
  logic                         pop_eff, wr_en;

  assign top_valid_o = (cnt != '0);
  assign pop_eff     = pop_i & top_valid_o;
  assign top_idx     = IDX_W'(cnt - 1'b1);
  assign wr_idx      = pop_eff ? top_idx : IDX_W'(cnt);
  assign wr_en       = push_i & (pop_eff | (cnt < CNT_W'(DEPTH)));
  assign top_id_o    = top_valid_o ? id_mem[top_idx] : '0;
  assign top_prio_o  = top_valid_o ? prio_mem[top_idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else begin
      unique case ({push_i, pop_eff})
        2'b10:   if (cnt < CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_mem   <= '0;
      prio_mem <= '0;
    end else if (wr_en) begin
      id_mem[wr_idx]   <= push_id_i;
      prio_mem[wr_idx] <= push_prio_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_eff |-> cnt < CNT_W'(DEPTH)); // R11
  AST_EMPTY_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !top_valid_o && !push_i |=> !top_valid_o); // R11
  AST_SWAP_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_eff |=> $stable(cnt)); // R6
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int unsigned NUM_IRQ = 35,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned ID_W    = $clog2(NUM_IRQ),
  localparam int unsigned DEPTH   = 1 << PRIO_W,
  localparam int unsigned SPLIT_W = $clog2(PRIO_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               take_i,
  input  logic               ret_i,
  output logic               req_o,
  output logic [ID_W-1:0]    req_id_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               act_valid_o,
  output logic [ID_W-1:0]    act_id_o
);
  import irq_pkg::*;

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic [SPLIT_W-1:0]             split;
  logic                           win_valid;
  logic [ID_W-1:0]                win_id;
  logic [PRIO_W-1:0]              win_prio, top_prio;
  logic [7:0]                     win_grp, top_grp;
  logic                           take_ok, ret_ok;
  logic [NUM_IRQ-1:0]             take_hit, ret_hit, act;

  irq_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .prio_o(prio), .split_o(split)
  );

  irq_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk_i, .rst_ni, .irq_i, .sw_set_i, .sw_clr_i, .act_i(act),
    .take_hit_i(take_hit), .ret_hit_i(ret_hit), .pend_o
  );

  irq_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .pend_i(pend_o), .prio_i(prio),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  irq_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
    .clk_i, .rst_ni, .push_i(take_ok), .pop_i(ret_i),
    .push_id_i(win_id), .push_prio_i(win_prio),
    .top_valid_o(act_valid_o), .top_id_o(act_id_o), .top_prio_o(top_prio)
  );

  assign win_grp  = group_of(8'(win_prio), 8'(split));
  assign top_grp  = group_of(8'(top_prio), 8'(split));
  assign req_o    = win_valid & (!act_valid_o | (win_grp < top_grp));
  assign req_id_o = win_id;
  assign take_ok  = take_i & req_o;
  assign ret_ok   = ret_i & act_valid_o;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
    assign take_hit[i] = take_ok && (win_id == ID_W'(i));
    assign ret_hit[i]  = ret_ok && (act_id_o == ID_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act <= '0;
    else         act <= (act & ~ret_hit) | take_hit;
  end

  AST_REQ_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> pend_o[req_id_o]); // R3
  AST_TAKE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && req_o |=> act_valid_o && act_id_o == $past(req_id_o)); // R4
  AST_RET_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && act_valid_o && !take_ok |=> !act[$past(act_id_o)]); // R6
  AST_TOP_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> act[act_id_o]); // R11
  AST_IDLE_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !req_o && !ret_i |=> $stable(act)); // R4
endmodule

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/100ps
module sim_irq_nest_ctrl;
  localparam int N = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0, sw_set = '0, sw_clr = '0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic take = 1'b0, ret = 1'b0;
  logic req, act_valid;
  logic [5:0] req_id, act_id;
  logic [N-1:0] pend;

  always #2.5 clk = ~clk;

  irq_nest_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .take_i(take), .ret_i(ret),
    .req_o(req), .req_id_o(req_id), .pend_o(pend), .act_valid_o(act_valid), .act_id_o(act_id)
  );

  typedef enum int {K_PEND, K_REQ, K_REQID, K_AVAL, K_AID} kind_t;
  typedef struct {kind_t kind; int idx; int exp; string tag;} item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int sample(kind_t k, int idx);
    case (k)
      K_PEND:  return int'(pend[idx]);
      K_REQ:   return int'(req);
      K_REQID: return int'(req_id);
      K_AVAL:  return int'(act_valid);
      default: return int'(act_id);
    endcase
  endfunction

  // monitor: pops expectations and compares against the ports
  initial forever begin
    item_t it;
    int got;
    wait (sb_q.size() != 0);
    it = sb_q.pop_front();
    got = sample(it.kind, it.idx);
    n_cmp++;
    if (got != it.exp) begin
      n_bad++;
      $display("FAIL %s kind=%0d idx=%0d actual=%0d expected=%0d", it.tag, it.kind, it.idx, got, it.exp);
    end
  end

  task automatic expect_v(kind_t k, int idx, int exp, string tag);
    item_t it;
    it.kind = k; it.idx = idx; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #0.1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 6'(a); wdata = 8'(d);
    step();
    we = 1'b0;
  endtask

  task automatic pulse_take();
    take = 1'b1; step(); take = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic set_sw(int n);
    sw_set[n] = 1'b1; step(); sw_set[n] = 1'b0;
  endtask

  task automatic clr_sw(int n);
    sw_clr[n] = 1'b1; step(); sw_clr[n] = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #12;
    rst_n = 1'b1;
    step();
    expect_v(K_REQ, 0, 0, "R1 req after reset");
    expect_v(K_AVAL, 0, 0, "R1 act_valid after reset");
    expect_v(K_PEND, 0, 0, "R1 pend0 after reset");
    // all priorities 0: two lines tie, lowest index wins
    sw_set[6] = 1'b1; sw_set[4] = 1'b1; step(); sw_set = '0;
    expect_v(K_REQID, 0, 4, "R1 priorities reset to 0 (tie)");
    sw_clr = '1; step(); sw_clr = '0;

    wr(0, 5); wr(3, 2); wr(7, 2); wr(34, 9); wr(10, 1);

    irq[34] = 1'b1; step();
    expect_v(K_PEND, 34, 1, "R2 level sets pend34");
    expect_v(K_REQ, 0, 1, "R2 req raised");
    expect_v(K_REQID, 0, 34, "R10 prio written, id34 offered");

    irq[3] = 1'b1; irq[7] = 1'b1; step();
    expect_v(K_REQID, 0, 3, "R3 tie lowest id wins");

    pulse_take();
    expect_v(K_AID, 0, 3, "R4 taken id on stack");
    expect_v(K_AVAL, 0, 1, "R4 act_valid");
    expect_v(K_PEND, 3, 1, "R4 stays pending while line high");
    expect_v(K_REQ, 0, 0, "R5 equal group no preemption");

    irq[3] = 1'b0; step();
    clr_sw(3);
    expect_v(K_PEND, 3, 0, "R9 sw clear");
    irq[3] = 1'b1; step();
    expect_v(K_PEND, 3, 1, "R8 rising edge while active");

    irq[10] = 1'b1; step();
    expect_v(K_REQ, 0, 1, "R5 more urgent group preempts");
    expect_v(K_REQID, 0, 10, "R5 preempting id");
    pulse_take();
    expect_v(K_AID, 0, 10, "R4 nested take");
    irq[10] = 1'b0; step();
    clr_sw(10);
    expect_v(K_REQ, 0, 0, "R5 no req after nested take");

    wr(0, 0); wr(63, 2);
    irq[0] = 1'b1; step();
    expect_v(K_REQID, 0, 0, "R3 winner id0");
    expect_v(K_REQ, 0, 0, "R5 subpriority alone does not preempt");
    wr(63, 0);
    expect_v(K_REQ, 0, 1, "R5 split 0 makes group more urgent");
    irq[0] = 1'b0; step();
    clr_sw(0);

    wr(63, 7);
    wr(0, 15);
    sw_set[0] = 1'b1; step(); sw_set[0] = 1'b0;
    // split clamps to 4: all groups 0, nothing preempts top (prio1)
    wr(5, 0);
    sw_set[5] = 1'b1; step(); sw_set[5] = 1'b0;
    expect_v(K_REQ, 0, 0, "R10 split clamped to 4");
    sw_clr[0] = 1'b1; sw_clr[5] = 1'b1; step(); sw_clr = '0;
    wr(63, 0);

    pulse_ret();
    expect_v(K_AID, 0, 3, "R6 return exposes lower handler");
    expect_v(K_PEND, 10, 0, "R6 retired line idle");

    clr_sw(3);
    expect_v(K_PEND, 3, 0, "R9 clear while active");
    pulse_ret();
    expect_v(K_PEND, 3, 1, "R7 re-pend on return");
    expect_v(K_AVAL, 0, 0, "R7 stack empty");
    expect_v(K_REQ, 0, 1, "R7 re-offered");
    expect_v(K_REQID, 0, 3, "R7 re-offered id");

    clr_sw(3);
    expect_v(K_PEND, 3, 0, "R9 clear beats level");
    step();
    expect_v(K_PEND, 3, 1, "R2 level re-sets after clear");

    sw_set[20] = 1'b1; sw_clr[20] = 1'b1; step(); sw_set = '0; sw_clr = '0;
    expect_v(K_PEND, 20, 1, "R9 set beats clear");

    irq = '0; sw_clr = '1; step(); sw_clr = '0;
    expect_v(K_REQ, 0, 0, "R9 all cleared");
    pulse_take();
    expect_v(K_AVAL, 0, 0, "R4 take without req ignored");
    pulse_ret();
    expect_v(K_AVAL, 0, 0, "R11 return on empty ignored");

    set_sw(34);
    pulse_take();
    expect_v(K_AID, 0, 34, "R6 outer handler");
    set_sw(7);
    pulse_take();
    expect_v(K_AID, 0, 7, "R6 second handler");
    set_sw(10);
    expect_v(K_REQID, 0, 10, "R5 deeper preempt offered");
    take = 1'b1; ret = 1'b1; step(); take = 1'b0; ret = 1'b0;
    expect_v(K_AID, 0, 10, "R6 take+ret replaces top");
    expect_v(K_PEND, 10, 0, "R4 taken line drops pending");
    pulse_ret();
    expect_v(K_AID, 0, 34, "R6 LIFO after swap");
    expect_v(K_AVAL, 0, 1, "R6 depth kept on swap");
    pulse_ret();
    expect_v(K_AVAL, 0, 0, "R11 empty after last return");

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule